// File: doc/BRIEF.md
# SPI Master Controller with Word FIFOs

This block is a memory-mapped SPI bus master. Software reaches it through a simple 32-bit register port with a write strobe, a read strobe and a byte address. Words written to the transmit data location queue up in a transmit FIFO. A shift engine serialises each word onto MOSI while it generates SCLK, and it assembles the word that comes back on MISO into a receive FIFO. Software drains that FIFO through the receive data location.

A hold bit stops the shift engine, so software can load a complete burst before the first SCLK edge. Chip selects are active-low and come from a slave-select register that software writes directly. In manual-select mode that register drives the pins for the whole burst. Otherwise the chosen selects are asserted only while a word is moving. A loopback bit feeds MOSI back into the receive path for self-test. Clock polarity, clock phase and bit order can be set from software. Word width, FIFO depth, select count and the SCLK divider are fixed at build time.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, control reads 0x100 (transmit hold set), status reads 0x05 (both FIFOs empty), every ss_n pin is high and sclk is low.
- R2: Control bits read back as written. The positions are: 0 loopback, 1 enable, 2 master, 3 CPOL, 4 CPHA, 7 manual select, 8 transmit hold, 9 LSB first. Bits 5 and 6 always read 0.
- R3: While the transmit hold bit (control bit 8) is set, writes to offset 0x68 still enter the transmit FIFO and status bit 2 (transmit empty) drops to 0, but SCLK does not toggle. Clearing the bit sends every queued word in order.
- R4: No word is shifted unless both enable (bit 1) and master (bit 2) are set. A queued word waits until both are set.
- R5: With bit 9 clear, words leave MOSI MSB first. With bit 9 set they leave LSB first, and the received word is assembled LSB first as well.
- R6: SCLK idles at the level of CPOL (bit 3). With CPHA (bit 4) clear, MISO is sampled on the first edge of each bit period. With CPHA set, it is sampled on the second edge.
- R7: With loopback (bit 0) set, the received word equals the transmitted word, whatever MISO does.
- R8: The slave-select register (offset 0x70, active low, one bit per select) drives ss_n continuously while manual select (bit 7) is set. With bit 7 clear, ss_n carries that value only while a word is being shifted and is all ones otherwise.
- R9: The transmit FIFO holds DEPTH words. A write to a full FIFO is dropped, and status bit 3 reports full.
- R10: Reading offset 0x6C pops the oldest received word. Reading it while the FIFO is empty returns 0. Status bit 0 reports receive empty and bit 1 reports receive full.
- R11: A word that completes while the receive FIFO is full is discarded, and rx_overrun pulses high for one clock.
- R12: Writing control with bit 5 set empties the transmit FIFO. Writing it with bit 6 set empties the receive FIFO. Neither bit stays set.
- R13: Each word produces exactly 2*WORD_W SCLK edges, spaced SCLK_HALF clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on reg_rdata one cycle later |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slaves |
| miso | input | 1 | Serial data from the slaves |
| ss_n | output | NSEL | Active-low slave selects |
| rx_overrun | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
The bench attacks the transmit hold bit. A controller that ignores the hold would start clocking as soon as the first word is written, and its SCLK edge count would be non-zero before the hold is released. A slave model in the bench drives MISO and captures MOSI in two clock modes and in both bit orders. A design that samples on the wrong edge or reverses the bit order returns a wrong word on one side. The bench also fills both FIFOs to the brim. A design that keeps the seventeenth transmit word, overwrites a full receive FIFO or skips the overrun pulse shows up as a wrong readback sequence or a wrong pulse count. Finally, the bench checks that the FIFO reset bits empty their FIFO and never read back as set.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SSEL = 8'h70;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXRST = 5;
  localparam int CB_RXRST = 6;
  localparam int CB_MANSS = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSBF  = 9;

  typedef struct packed {
    logic lsb_first;
    logic hold;
    logic man_ss;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
    logic loop;
  } ctrl_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R9: a push into a full queue changes nothing
  assert_full_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (cnt == $past(cnt)));

  // R12: a flush leaves the queue empty
  assert_flush_empty_R12: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W   = 8,
  parameter int DIV = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] word,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         loop,
  input  logic         miso,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rx_word,
  output logic         sclk,
  output logic         mosi
);
  localparam int CNTW  = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int EW    = $clog2(2 * W);
  localparam int LASTE = 2 * W - 1;

  logic [CNTW-1:0] cnt;
  logic [EW-1:0]   eidx;
  logic [W-1:0]    tx_sh, rx_sh;
  logic            busy_q, done_q, sclk_q, mosi_q;
  logic            tick, lead, drive, samp, rx_in;

  function automatic logic pick(input logic [W-1:0] x, input logic lsb);
    return lsb ? x[0] : x[W-1];
  endfunction

  function automatic logic [W-1:0] adv(input logic [W-1:0] x, input logic lsb);
    return lsb ? (x >> 1) : (x << 1);
  endfunction

  assign tick  = busy_q && (cnt == CNTW'(DIV - 1));
  assign lead  = !eidx[0];
  assign drive = tick && (lead == cpha);
  assign samp  = tick && (lead != cpha);
  assign rx_in = loop ? mosi_q : miso;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      cnt    <= '0;
      eidx   <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        sclk_q <= cpol;
        cnt    <= '0;
        eidx   <= '0;
        if (start) begin
          busy_q <= 1'b1;
          if (!cpha) begin
            mosi_q <= pick(word, lsb_first);
            tx_sh  <= adv(word, lsb_first);
          end else begin
            tx_sh  <= word;
          end
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          sclk_q <= ~sclk_q;
          eidx   <= eidx + 1'b1;
          if (drive) begin
            mosi_q <= pick(tx_sh, lsb_first);
            tx_sh  <= adv(tx_sh, lsb_first);
          end
          if (samp)
            rx_sh <= lsb_first ? {rx_in, rx_sh[W-1:1]} : {rx_sh[W-2:0], rx_in};
          if (eidx == EW'(LASTE)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_word = rx_sh;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  // R6: an idle engine parks SCLK at the polarity level
  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q) && $stable(cpol)) |-> (sclk_q == cpol));

  // R13: after the full edge count SCLK is back at its idle level
  assert_sclk_home_R13: assert property (@(posedge clk) disable iff (rst)
    (done_q && $stable(cpol)) |-> (sclk_q == cpol));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int DEPTH     = 16,
  parameter int NSEL      = 4,
  parameter int SCLK_HALF = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NSEL-1:0]   ss_n,
  output logic              rx_overrun
);
  ctrl_t            ctl;
  logic [NSEL-1:0]  ssr, ss_q;
  logic [31:0]      rdata_q;
  logic             ovr_q;
  logic             sel_ctrl, sel_stat, sel_txd, sel_rxd, sel_ssel;
  logic             tx_flush, rx_flush, tx_push, rx_pop;
  logic             tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_dout, rx_dout, rx_word;
  logic             busy, done, start;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign sel_ctrl = (reg_addr == ADDR_W'(OFF_CTRL));
  assign sel_stat = (reg_addr == ADDR_W'(OFF_STAT));
  assign sel_txd  = (reg_addr == ADDR_W'(OFF_TXD));
  assign sel_rxd  = (reg_addr == ADDR_W'(OFF_RXD));
  assign sel_ssel = (reg_addr == ADDR_W'(OFF_SSEL));

  assign tx_flush = reg_wr && sel_ctrl && reg_wdata[CB_TXRST];
  assign rx_flush = reg_wr && sel_ctrl && reg_wdata[CB_RXRST];
  assign tx_push  = reg_wr && sel_txd;
  assign rx_pop   = reg_rd && sel_rxd;
  assign start    = !busy && ctl.enable && ctl.master && !ctl.hold && !tx_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl      <= '0;
      ctl.hold <= 1'b1;
      ssr      <= '1;
    end else if (reg_wr) begin
      if (sel_ctrl) begin
        ctl.loop      <= reg_wdata[CB_LOOP];
        ctl.enable    <= reg_wdata[CB_EN];
        ctl.master    <= reg_wdata[CB_MST];
        ctl.cpol      <= reg_wdata[CB_CPOL];
        ctl.cpha      <= reg_wdata[CB_CPHA];
        ctl.man_ss    <= reg_wdata[CB_MANSS];
        ctl.hold      <= reg_wdata[CB_HOLD];
        ctl.lsb_first <= reg_wdata[CB_LSBF];
      end
      if (sel_ssel) ssr <= reg_wdata[NSEL-1:0];
    end
  end

  spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush), .push(tx_push),
    .din(reg_wdata[WORD_W-1:0]), .pop(start), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush), .push(done),
    .din(rx_word), .pop(rx_pop), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full)
  );

  spim_shift #(.W(WORD_W), .DIV(SCLK_HALF)) u_eng (
    .clk(clk), .rst(rst), .start(start), .word(tx_dout),
    .cpol(ctl.cpol), .cpha(ctl.cpha), .lsb_first(ctl.lsb_first),
    .loop(ctl.loop), .miso(miso), .busy(busy), .done(done),
    .rx_word(rx_word), .sclk(sclk), .mosi(mosi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      ss_q    <= '1;
      ovr_q   <= 1'b0;
    end else begin
      ss_q  <= (ctl.man_ss || busy || start) ? ssr : '1;
      ovr_q <= done && rx_full;
      rdata_q <= '0;
      if (reg_rd) begin
        if (sel_ctrl)
          rdata_q <= {22'b0, ctl.lsb_first, ctl.hold, ctl.man_ss, 2'b00,
                      ctl.cpha, ctl.cpol, ctl.master, ctl.enable, ctl.loop};
        else if (sel_stat)
          rdata_q <= {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
        else if (sel_rxd)
          rdata_q <= rx_empty ? '0 : 32'(rx_dout);
        else if (sel_ssel)
          rdata_q <= {{(32 - NSEL){1'b1}}, ssr};
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign ss_n       = ss_q;
  assign rx_overrun = ovr_q;

  // R3: a held transmitter never starts a word
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (ctl.hold && !busy) |=> !busy);

  // R4: no shifting without both enable and master
  assert_gate_idle_R4: assert property (@(posedge clk) disable iff (rst)
    ((!ctl.enable || !ctl.master) && !busy) |=> !busy);

  // R8: manual select drives the register value onto the pins
  assert_manual_ss_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.man_ss |=> (ss_n == $past(ssr)));

  // R11: the overrun pulse follows a completion into a full queue
  assert_overrun_src_R11: assert property (@(posedge clk) disable iff (rst)
    rx_overrun |-> ($past(rx_full) && $past(done)));

  // R10: an empty receive read returns zero
  assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel_rxd && rx_empty) |=> (reg_rdata == 32'd0));
endmodule

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
  localparam int W = 8, DEPTH = 16, NSEL = 4, DIV = 2;
  localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                         A_RXD = 8'h6C, A_SSEL = 8'h70;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, miso = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic sclk, mosi, rx_overrun;
  logic [NSEL-1:0] ss_n;

  always #10 clk = ~clk;

  spim_ctrl #(.WORD_W(W), .DEPTH(DEPTH), .NSEL(NSEL), .SCLK_HALF(DIV), .ADDR_W(8)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .rx_overrun(rx_overrun)
  );

  int checks = 0, errors = 0;
  int cyc = 0, edges = 0, last_edge = 0, min_gap = 999, ovr_cnt = 0, ss_bad = 0;
  logic sclk_prev = 0, slv_en = 0, slv_cpol = 0, slv_cpha = 0, ss_watch = 0;
  logic [7:0] slv_tx = 0, slv_rx = 0;
  logic [NSEL-1:0] ss_expect = '1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slave_arm(input logic pol, input logic pha, input logic [7:0] word);
    slv_cpol = pol; slv_cpha = pha; slv_tx = word; slv_rx = 0;
    if (!pha) begin miso = slv_tx[7]; slv_tx = {slv_tx[6:0], 1'b0}; end
    slv_en = 1;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (sclk !== sclk_prev) begin
      edges++;
      if (last_edge > 0 && cyc - last_edge < min_gap) min_gap = cyc - last_edge;
      last_edge = cyc;
      if (slv_en) begin
        if ((sclk != slv_cpol) ^ slv_cpha) slv_rx = {slv_rx[6:0], mosi};
        else begin miso = slv_tx[7]; slv_tx = {slv_tx[6:0], 1'b0}; end
      end
    end
    sclk_prev = sclk;
    if (rx_overrun) ovr_cnt++;
    if (ss_watch && ss_n !== ss_expect) ss_bad++;
  end

  task automatic t_reset;
    logic [31:0] d;
    rd(A_CTRL, d); check("R1 ctrl reset", d, 32'h100);
    rd(A_STAT, d); check("R1 status reset", d, 32'h05);
    check("R1 ss_n reset", 32'(ss_n), 32'hF);
    check("R1 sclk reset", 32'(sclk), 32'h0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    wr(A_CTRL, 32'h3FF); rd(A_CTRL, d); check("R2 all bits", d, 32'h39F);
    wr(A_CTRL, 32'h001); rd(A_CTRL, d); check("R2 loopback only", d, 32'h001);
  endtask

  task automatic t_hold;
    logic [31:0] d;
    miso = 1;
    wr(A_SSEL, 32'hE);
    wr(A_CTRL, 32'h187);
    edges = 0;
    wr(A_TXD, 32'hA5); wr(A_TXD, 32'h3C);
    idle(40);
    check("R3 no edges while held", 32'(edges), 0);
    rd(A_STAT, d); check("R3 queued while held", d, 32'h01);
    ss_expect = 4'hE; ss_watch = 1; edges = 0; min_gap = 999; last_edge = 0;
    wr(A_CTRL, 32'h087);
    idle(100);
    ss_watch = 0;
    check("R8 manual select held over burst", 32'(ss_bad), 0);
    check("R13 edge count two words", 32'(edges), 32);
    check("R13 half period", 32'(min_gap), DIV);
    rd(A_STAT, d); check("R3 drained after release", d, 32'h04);
    rd(A_RXD, d); check("R7 loopback word 1", d, 32'hA5);
    rd(A_RXD, d); check("R7 loopback word 2", d, 32'h3C);
    check("R8 select still asserted", 32'(ss_n), 32'hE);
    miso = 0;
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(A_CTRL, 32'h183); wr(A_TXD, 32'h66);
    wr(A_CTRL, 32'h083); edges = 0; idle(60);
    check("R4 no master no shift", 32'(edges), 0);
    rd(A_STAT, d); check("R4 word still queued", d, 32'h01);
    wr(A_CTRL, 32'h085); idle(60);
    check("R4 no enable no shift", 32'(edges), 0);
    wr(A_CTRL, 32'h087); idle(60);
    rd(A_RXD, d); check("R4 word sent once gated on", d, 32'h66);
  endtask

  task automatic t_modes;
    logic [31:0] d;
    wr(A_CTRL, 32'h186);
    slave_arm(0, 0, 8'h96);
    wr(A_TXD, 32'h5A); wr(A_CTRL, 32'h086); idle(60); slv_en = 0;
    check("R6 mode0 slave saw", 32'(slv_rx), 32'h5A);
    rd(A_RXD, d); check("R6 mode0 received", d, 32'h96);
    wr(A_CTRL, 32'h19E); idle(3);
    check("R6 idle high with CPOL", 32'(sclk), 1);
    slave_arm(1, 1, 8'hE1);
    wr(A_TXD, 32'h33); wr(A_CTRL, 32'h09E); idle(60); slv_en = 0;
    check("R6 mode3 slave saw", 32'(slv_rx), 32'h33);
    rd(A_RXD, d); check("R6 mode3 received", d, 32'hE1);
    check("R6 idle high after word", 32'(sclk), 1);
  endtask

  task automatic t_lsb;
    logic [31:0] d;
    wr(A_CTRL, 32'h386); idle(3);
    slave_arm(0, 0, 8'h2C);
    wr(A_TXD, 32'h0D); wr(A_CTRL, 32'h286); idle(60); slv_en = 0;
    check("R5 lsb first on mosi", 32'(slv_rx), 32'hB0);
    rd(A_RXD, d); check("R5 lsb first assembly", d, 32'h34);
  endtask

  task automatic t_auto_ss;
    logic [31:0] d;
    wr(A_SSEL, 32'hD); wr(A_CTRL, 32'h107); idle(2);
    check("R8 auto select idle", 32'(ss_n), 32'hF);
    wr(A_TXD, 32'h77); wr(A_CTRL, 32'h007); idle(10);
    check("R8 auto select during word", 32'(ss_n), 32'hD);
    idle(50);
    check("R8 auto select after word", 32'(ss_n), 32'hF);
    rd(A_RXD, d); check("R8 auto word looped", d, 32'h77);
  endtask

  task automatic t_full;
    logic [31:0] d;
    wr(A_CTRL, 32'h187);
    for (int i = 0; i < DEPTH + 1; i++) wr(A_TXD, 32'h10 + i);
    rd(A_STAT, d); check("R9 tx full flag", d, 32'h09);
    ovr_cnt = 0;
    wr(A_CTRL, 32'h087); idle(DEPTH * 36 + 40);
    rd(A_STAT, d); check("R10 rx full flag", d, 32'h06);
    check("R11 no overrun yet", 32'(ovr_cnt), 0);
    wr(A_CTRL, 32'h187); wr(A_TXD, 32'hEE); wr(A_CTRL, 32'h087); idle(60);
    check("R11 single overrun pulse", 32'(ovr_cnt), 1);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_RXD, d); check("R9 R11 rx order", d, 32'h10 + i);
    end
    rd(A_STAT, d); check("R10 empty after drain", d, 32'h05);
    rd(A_RXD, d); check("R10 empty read zero", d, 32'h0);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    wr(A_CTRL, 32'h187);
    wr(A_TXD, 1); wr(A_TXD, 2); wr(A_TXD, 3);
    rd(A_STAT, d); check("R12 tx loaded", d, 32'h01);
    wr(A_CTRL, 32'h1A7);
    rd(A_STAT, d); check("R12 tx flushed", d, 32'h05);
    rd(A_CTRL, d); check("R12 reset bit self clears", d, 32'h187);
    wr(A_TXD, 4); wr(A_TXD, 5); wr(A_CTRL, 32'h087); idle(100);
    rd(A_STAT, d); check("R12 rx loaded", d, 32'h04);
    wr(A_CTRL, 32'h0C7);
    rd(A_STAT, d); check("R12 rx flushed", d, 32'h05);
  endtask

  logic finished = 0;

  always @(negedge clk) begin
    if (!finished && cyc > 100000) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 0;
    idle(2);
    t_reset();
    t_ctrl();
    t_hold();
    t_gate();
    t_modes();
    t_lsb();
    t_auto_ss();
    t_full();
    t_flush();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule